// File: doc/BRIEF.md
# Text Display Raster Sequencer

This block produces the dot stream for a character-cell text screen, 80 columns by 24 rows by default. A column counter and a row counter walk the display RAM, one character cell at a time. For each cell the block presents the RAM address and takes the 7-bit character code that comes back. It picks one 7-dot slice of that glyph for the current scan line and loads the slice into a video shift register, which then emits the dots one per clock. The fetch for a cell happens while the previous cell is still shifting out. As a result, the dots of column X appear one character time after X was addressed.

Each character row is made of seven glyph scans followed by a spacing band. The first scan of the band is the cursor scan, which is fully lit under the cursor cell only. The other scans of the band are dark. A mode input selects the short row (10 scans) or the tall row (11 scans), which sets the frame rate of a 60 Hz or a 50 Hz display. After the last row comes a vertical blanking interval. A one-clock strobe marks its start so that keyboard scanning can run once per frame. A small computed glyph table stands in for a character ROM: scan s of code c is c rotated left by s bit positions.

Top module: `rsq_top`

## Requirements
- R1: While reset is held, video, hsync, vsync and retraceStrobe are low and ramAddr is 0.
- R2: During every active scan of row Y, at character time X (0-based, X < COLS) ramAddr equals Y*COLS+X. At character times X >= COLS it equals Y*COLS. After vertical blanking the next frame starts again at row 0, address 0.
- R3: On glyph scan s (0..6) of row Y, during character time X+1 the first seven dot clocks show bits 6 down to 0 of the code at address Y*COLS+X rotated left by s. The remaining CELL_W-7 dot clocks of the cell are low.
- R4: Scan 7 of a row is the cursor scan. Its seven dots are all high for the cell at cursorX, cursorY. They are low for every other cell, and low everywhere when cursorY names no row.
- R5: The scans after the cursor scan are dark: two of them when mode50=0, three when mode50=1.
- R6: A frame lasts (ROWS*(10+mode50)+VBLANK_LINES) scan lines of (COLS+HBLANK_CHARS)*CELL_W clocks each.
- R7: Video is low during character time 0 and during character times above COLS on every scan line.
- R8: hsync is high exactly during character times HSYNC_START up to HSYNC_START+HSYNC_LEN-1 of every scan line.
- R9: During the VBLANK_LINES blanking lines video is low. vsync is high exactly on blanking lines VSYNC_START up to VSYNC_START+VSYNC_LEN-1 and never on active lines.
- R10: retraceStrobe is high for exactly one clock per frame, the first clock of the first blanking line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode50 | input | 1 | 1 selects 11-scan rows, 0 selects 10-scan rows |
| cursorX | input | $clog2(COLS) | Cursor column |
| cursorY | input | $clog2(ROWS) | Cursor row |
| ramData | input | 7 | Character code read from the display RAM at ramAddr |
| ramAddr | output | $clog2(COLS*ROWS) | Display RAM address being fetched |
| video | output | 1 | Dot intensity |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| retraceStrobe | output | 1 | One-clock pulse at the start of vertical blanking |

## Verification
The bench builds the block with 4 columns, 3 rows, 3 blanking character times, 9-clock cells and 4 blanking lines. A full frame is then about 2,100 to 2,300 clocks, so every dot of several whole frames can be compared against a model computed from the requirements. These small sizes put the last column, the last row, the row-to-blanking hand-off and the frame wrap in every frame. The cursor can be placed on the final cell, or on a row number that does not exist (3 with 2 row bits). Both row heights are run back to back, so the switch between them and the frame length in each mode are checked.

// File: rtl/rsq_pkg.sv
`timescale 1ns/1ps
package rsq_pkg;
  typedef enum logic [1:0] {
    SLICE_DARK   = 2'd0,
    SLICE_GLYPH  = 2'd1,
    SLICE_CURSOR = 2'd2
  } sliceKind_e;

  typedef struct packed {
    logic       load;      // last dot of a character time: load next slice
    logic       active;    // slice belongs to a visible cell
    sliceKind_e kind;      // what the slice is made of
    logic       rowNext;   // advance row base by one text row
    logic       frameClr;  // return row base to the top of the screen
  } seqStrobe_t;
endpackage

// File: rtl/rsq_ctrl.sv
`timescale 1ns/1ps
module rsq_ctrl
  import rsq_pkg::*;
#(
  parameter int COLS         = 80,
  parameter int ROWS         = 24,
  parameter int HBLANK_CHARS = 20,
  parameter int CELL_W       = 9,
  parameter int GLYPH_H      = 7,
  parameter int DARK_SCANS   = 2,
  parameter int VBLANK_LINES = 20,
  parameter int HSYNC_START  = 84,
  parameter int HSYNC_LEN    = 8,
  parameter int VSYNC_START  = 2,
  parameter int VSYNC_LEN    = 3,
  localparam int LINE_CHARS  = COLS + HBLANK_CHARS,
  localparam int C_W         = $clog2(LINE_CHARS),
  localparam int Y_W         = $clog2(ROWS),
  localparam int MAX_SCANS   = GLYPH_H + 2 + DARK_SCANS,
  localparam int S_W         = $clog2(MAX_SCANS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode50,
  input  logic [Y_W-1:0]   cursorY,
  output seqStrobe_t       strb,
  output logic [C_W-1:0]   colIdx,
  output logic [S_W-1:0]   scanIdx,
  output logic             hsync,
  output logic             vsync,
  output logic             retraceStrobe
);
  localparam int D_W = $clog2(CELL_W);
  localparam int V_W = $clog2(VBLANK_LINES);
  localparam logic [C_W:0] HS_BEG = (C_W+1)'(HSYNC_START);
  localparam logic [C_W:0] HS_END = (C_W+1)'(HSYNC_START + HSYNC_LEN);
  localparam logic [V_W:0] VS_BEG = (V_W+1)'(VSYNC_START);
  localparam logic [V_W:0] VS_END = (V_W+1)'(VSYNC_START + VSYNC_LEN);

  logic [D_W-1:0] dotCnt;
  logic [C_W-1:0] charCnt;
  logic [S_W-1:0] scanCnt;
  logic [Y_W-1:0] rowCnt;
  logic [V_W-1:0] vblCnt;
  logic           inVbl;

  logic dotEnd, lineEnd, rowLast, vblLast, scanLast;
  logic [S_W-1:0] lastScan;

  always_comb begin
    lastScan = mode50 ? S_W'(GLYPH_H + 1 + DARK_SCANS) : S_W'(GLYPH_H + DARK_SCANS);
    dotEnd   = (dotCnt == D_W'(CELL_W - 1));
    lineEnd  = dotEnd && (charCnt == C_W'(LINE_CHARS - 1));
    rowLast  = (rowCnt == Y_W'(ROWS - 1));
    vblLast  = (vblCnt == V_W'(VBLANK_LINES - 1));
    scanLast = (scanCnt >= lastScan);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dotCnt  <= '0;
      charCnt <= '0;
      scanCnt <= '0;
      rowCnt  <= '0;
      vblCnt  <= '0;
      inVbl   <= 1'b0;
    end else begin
      dotCnt <= dotEnd ? '0 : dotCnt + 1'b1;
      if (dotEnd) charCnt <= lineEnd ? '0 : charCnt + 1'b1;
      if (lineEnd) begin
        if (inVbl) begin
          if (vblLast) begin
            inVbl   <= 1'b0;
            vblCnt  <= '0;
            rowCnt  <= '0;
            scanCnt <= '0;
          end else begin
            vblCnt <= vblCnt + 1'b1;
          end
        end else if (scanLast) begin
          scanCnt <= '0;
          if (rowLast) begin
            inVbl  <= 1'b1;
            vblCnt <= '0;
          end else begin
            rowCnt <= rowCnt + 1'b1;
          end
        end else begin
          scanCnt <= scanCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strb.load     = dotEnd;
    strb.active   = !inVbl && (charCnt < C_W'(COLS));
    strb.rowNext  = lineEnd && !inVbl && scanLast && !rowLast;
    strb.frameClr = lineEnd && inVbl && vblLast;
    if (scanCnt < S_W'(GLYPH_H))
      strb.kind = SLICE_GLYPH;
    else if (scanCnt == S_W'(GLYPH_H) && rowCnt == cursorY)
      strb.kind = SLICE_CURSOR;
    else
      strb.kind = SLICE_DARK;
  end

  assign colIdx        = charCnt;
  assign scanIdx       = scanCnt;
  assign hsync         = ({1'b0, charCnt} >= HS_BEG) && ({1'b0, charCnt} < HS_END);
  assign vsync         = inVbl && ({1'b0, vblCnt} >= VS_BEG) && ({1'b0, vblCnt} < VS_END);
  assign retraceStrobe = inVbl && (vblCnt == '0) && (charCnt == '0) && (dotCnt == '0);
endmodule

// File: rtl/rsq_datapath.sv
`timescale 1ns/1ps
module rsq_datapath
  import rsq_pkg::*;
#(
  parameter int COLS    = 80,
  parameter int ROWS    = 24,
  parameter int CELL_W  = 9,
  parameter int GLYPH_W = 7,
  parameter int C_W     = 7,
  parameter int S_W     = 4,
  parameter int X_W     = 7,
  localparam int A_W    = $clog2(COLS * ROWS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  seqStrobe_t         strb,
  input  logic [C_W-1:0]     colIdx,
  input  logic [S_W-1:0]     scanIdx,
  input  logic [X_W-1:0]     cursorX,
  input  logic [GLYPH_W-1:0] ramData,
  output logic [A_W-1:0]     ramAddr,
  output logic               video
);
  logic [A_W-1:0]       rowBase;
  logic [GLYPH_W-1:0]   slice;
  logic [2*GLYPH_W-1:0] dbl;
  logic [CELL_W-1:0]    loadWord;
  logic [CELL_W-1:0]    shReg;
  logic                 shValid;

  // Y register kept as the address of column 0 of the current text row
  always_ff @(posedge clk) begin
    if (!rst_n)             rowBase <= '0;
    else if (strb.frameClr) rowBase <= '0;
    else if (strb.rowNext)  rowBase <= rowBase + A_W'(COLS);
  end

  assign ramAddr = rowBase + ((colIdx < C_W'(COLS)) ? A_W'(colIdx) : '0);

  // Stand-in glyph table: scan s is the code rotated left by s
  always_comb begin
    dbl = {ramData, ramData} << scanIdx;
    unique case (strb.kind)
      SLICE_GLYPH:  slice = dbl[2*GLYPH_W-1:GLYPH_W];
      SLICE_CURSOR: slice = (colIdx == C_W'(cursorX)) ? '1 : '0;
      default:      slice = '0;
    endcase
  end

  generate
    if (CELL_W > GLYPH_W) begin : g_gap
      assign loadWord = {slice, {(CELL_W - GLYPH_W){1'b0}}};
    end else begin : g_noGap
      assign loadWord = slice[GLYPH_W-1 -: CELL_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shReg   <= '0;
      shValid <= 1'b0;
    end else if (strb.load) begin
      shReg   <= loadWord;
      shValid <= strb.active;
    end else begin
      shReg   <= shReg << 1;
    end
  end

  assign video = shReg[CELL_W-1] & shValid;
endmodule

// File: rtl/rsq_top.sv
`timescale 1ns/1ps
module rsq_top
  import rsq_pkg::*;
#(
  parameter int COLS         = 80,
  parameter int ROWS         = 24,
  parameter int HBLANK_CHARS = 20,
  parameter int CELL_W       = 9,
  parameter int GLYPH_W      = 7,
  parameter int GLYPH_H      = 7,
  parameter int DARK_SCANS   = 2,
  parameter int VBLANK_LINES = 20,
  parameter int HSYNC_START  = 84,
  parameter int HSYNC_LEN    = 8,
  parameter int VSYNC_START  = 2,
  parameter int VSYNC_LEN    = 3,
  localparam int X_W         = $clog2(COLS),
  localparam int Y_W         = $clog2(ROWS),
  localparam int A_W         = $clog2(COLS * ROWS),
  localparam int C_W         = $clog2(COLS + HBLANK_CHARS),
  localparam int S_W         = $clog2(GLYPH_H + 2 + DARK_SCANS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode50,
  input  logic [X_W-1:0]     cursorX,
  input  logic [Y_W-1:0]     cursorY,
  input  logic [GLYPH_W-1:0] ramData,
  output logic [A_W-1:0]     ramAddr,
  output logic               video,
  output logic               hsync,
  output logic               vsync,
  output logic               retraceStrobe
);
  seqStrobe_t     strb;
  logic [C_W-1:0] colIdx;
  logic [S_W-1:0] scanIdx;

  rsq_ctrl #(
    .COLS(COLS), .ROWS(ROWS), .HBLANK_CHARS(HBLANK_CHARS), .CELL_W(CELL_W),
    .GLYPH_H(GLYPH_H), .DARK_SCANS(DARK_SCANS), .VBLANK_LINES(VBLANK_LINES),
    .HSYNC_START(HSYNC_START), .HSYNC_LEN(HSYNC_LEN),
    .VSYNC_START(VSYNC_START), .VSYNC_LEN(VSYNC_LEN)
  ) ctrl (
    .clk(clk), .rst_n(rst_n), .mode50(mode50), .cursorY(cursorY),
    .strb(strb), .colIdx(colIdx), .scanIdx(scanIdx),
    .hsync(hsync), .vsync(vsync), .retraceStrobe(retraceStrobe)
  );

  rsq_datapath #(
    .COLS(COLS), .ROWS(ROWS), .CELL_W(CELL_W), .GLYPH_W(GLYPH_W),
    .C_W(C_W), .S_W(S_W), .X_W(X_W)
  ) dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb), .colIdx(colIdx), .scanIdx(scanIdx),
    .cursorX(cursorX), .ramData(ramData), .ramAddr(ramAddr), .video(video)
  );
endmodule

// File: rtl/rsq_chk.sv
`timescale 1ns/1ps
module rsq_chk #(
  parameter int A_W   = 11,
  parameter int CELLS = 1920
) (
  input logic           clk,
  input logic           rst_n,
  input logic           video,
  input logic           hsync,
  input logic           vsync,
  input logic           retraceStrobe,
  input logic [A_W-1:0] ramAddr
);
  // R10
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retraceStrobe |=> !retraceStrobe);
  // R10
  strobe_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retraceStrobe |-> !video);
  // R8
  hsync_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |-> !video);
  // R9
  vsync_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |-> !video);
  // R2
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, ramAddr} < (A_W+1)'(CELLS));
endmodule

bind rsq_top rsq_chk #(.A_W(A_W), .CELLS(COLS * ROWS)) chkInst (
  .clk(clk), .rst_n(rst_n), .video(video), .hsync(hsync), .vsync(vsync),
  .retraceStrobe(retraceStrobe), .ramAddr(ramAddr)
);

// File: tb/tb_rsq_top.sv
`timescale 1ns/1ps
module tb_rsq_top;
  localparam int COLS = 4, ROWS = 3, HBL = 3, CELL_W = 9, GW = 7, GH = 7;
  localparam int DARK = 2, VBL = 4, HS0 = 5, HSL = 1, VS0 = 1, VSL = 2;
  localparam int LINE_CHARS = COLS + HBL;
  localparam int CELLS = COLS * ROWS;
  localparam int A_W = $clog2(CELLS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode50 = 1'b0;
  logic [1:0] cursorX = '0;
  logic [1:0] cursorY = '0;
  logic [GW-1:0] ramData;
  logic [A_W-1:0] ramAddr;
  logic video, hsync, vsync, retraceStrobe;
  logic [GW-1:0] mem [CELLS];

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  assign ramData = (int'(ramAddr) < CELLS) ? mem[ramAddr] : '0;

  rsq_top #(
    .COLS(COLS), .ROWS(ROWS), .HBLANK_CHARS(HBL), .CELL_W(CELL_W),
    .GLYPH_W(GW), .GLYPH_H(GH), .DARK_SCANS(DARK), .VBLANK_LINES(VBL),
    .HSYNC_START(HS0), .HSYNC_LEN(HSL), .VSYNC_START(VS0), .VSYNC_LEN(VSL)
  ) dut (
    .clk(clk), .rst_n(rst_n), .mode50(mode50), .cursorX(cursorX), .cursorY(cursorY),
    .ramData(ramData), .ramAddr(ramAddr), .video(video), .hsync(hsync),
    .vsync(vsync), .retraceStrobe(retraceStrobe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [GW-1:0] rotl(input logic [GW-1:0] c, input int s);
    logic [GW-1:0] o;
    for (int b = 0; b < GW; b++) o[(b + s) % GW] = c[b];
    return o;
  endfunction

  // R1
  task automatic testReset();
    rst_n = 1'b0;
    repeat (3) step();
    check(video == 1'b0, "R1", video, 0, "video in reset");
    check(hsync == 1'b0, "R1", hsync, 0, "hsync in reset");
    check(vsync == 1'b0, "R1", vsync, 0, "vsync in reset");
    check(retraceStrobe == 1'b0, "R1", retraceStrobe, 0, "strobe in reset");
    check(ramAddr == '0, "R1", ramAddr, 0, "ramAddr in reset");
    rst_n = 1'b1;
  endtask

  // Walks one whole frame from the retrace strobe and compares every clock.
  task automatic runFrame(input logic m50, input int cx, input int cy, input string tag);
    int errs [8];
    int fAct [8];
    int fExp [8];
    string reqs [8] = '{"R2", "R3", "R4", "R5", "R7", "R8", "R9", "R10"};
    int nScans, guard, cat, expV, expA;
    bit expHs;
    logic [GW-1:0] sl;
    mode50 = m50;
    cursorX = cx[1:0];
    cursorY = cy[1:0];
    nScans = GH + 1 + DARK + int'(m50);
    for (int i = 0; i < 8; i++) errs[i] = 0;
    guard = 0;
    while (!retraceStrobe && guard < 6000) begin
      step();
      guard++;
    end
    check(retraceStrobe == 1'b1, "R10", retraceStrobe, 1, {tag, " strobe seen"});
    // blanking lines
    for (int vl = 0; vl < VBL; vl++)
      for (int t = 0; t < LINE_CHARS; t++)
        for (int d = 0; d < CELL_W; d++) begin
          expHs = (t >= HS0) && (t < HS0 + HSL);
          if (hsync !== expHs) begin
            if (errs[5] == 0) begin fAct[5] = hsync; fExp[5] = expHs; end
            errs[5]++;
          end
          if (video !== 1'b0 || vsync !== ((vl >= VS0) && (vl < VS0 + VSL))) begin
            if (errs[6] == 0) begin fAct[6] = {vsync, video}; fExp[6] = ((vl >= VS0) && (vl < VS0 + VSL)) ? 2 : 0; end
            errs[6]++;
          end
          if (retraceStrobe !== (vl == 0 && t == 0 && d == 0)) begin
            if (errs[7] == 0) begin fAct[7] = retraceStrobe; fExp[7] = (vl == 0 && t == 0 && d == 0); end
            errs[7]++;
          end
          step();
        end
    // active rows
    for (int r = 0; r < ROWS; r++)
      for (int s = 0; s < nScans; s++)
        for (int t = 0; t < LINE_CHARS; t++)
          for (int d = 0; d < CELL_W; d++) begin
            expA = r * COLS + ((t < COLS) ? t : 0);
            if (int'(ramAddr) != expA) begin
              if (errs[0] == 0) begin fAct[0] = ramAddr; fExp[0] = expA; end
              errs[0]++;
            end
            if (t >= 1 && t <= COLS && d < GW) begin
              if (s < GH) begin
                cat = 1;
                sl = rotl(mem[r * COLS + t - 1], s);
              end else if (s == GH) begin
                cat = 2;
                sl = (r == cy && (t - 1) == cx) ? '1 : '0;
              end else begin
                cat = 3;
                sl = '0;
              end
              expV = sl[GW - 1 - d];
            end else begin
              cat = 4;
              expV = 0;
            end
            if (int'(video) != expV) begin
              if (errs[cat] == 0) begin fAct[cat] = video; fExp[cat] = expV; end
              errs[cat]++;
            end
            expHs = (t >= HS0) && (t < HS0 + HSL);
            if (hsync !== expHs) begin
              if (errs[5] == 0) begin fAct[5] = hsync; fExp[5] = expHs; end
              errs[5]++;
            end
            if (vsync !== 1'b0) begin
              if (errs[6] == 0) begin fAct[6] = {vsync, 1'b0}; fExp[6] = 0; end
              errs[6]++;
            end
            if (retraceStrobe !== 1'b0) begin
              if (errs[7] == 0) begin fAct[7] = retraceStrobe; fExp[7] = 0; end
              errs[7]++;
            end
            step();
          end
    for (int i = 0; i < 8; i++)
      check(errs[i] == 0, reqs[i], fAct[i], fExp[i], {tag, " first mismatch over frame"});
    // R6: the next frame's strobe arrives exactly one frame length later
    check(retraceStrobe == 1'b1, "R6", retraceStrobe, 1, {tag, " frame length"});
  endtask

  task automatic loadPattern(input int kind);
    for (int i = 0; i < CELLS; i++)
      case (kind)
        0: mem[i] = 7'(8'h41 + i);
        1: mem[i] = 7'((i * 37 + 5) % 128);
        default: mem[i] = 7'h7F;
      endcase
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run did not complete actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    loadPattern(0);
    #1;
    testReset();
    // short rows, cursor on an interior cell (R2 R3 R4 R5 R6 R7 R8 R9 R10)
    runFrame(1'b0, 1, 0, "60Hz cursor(1,0)");
    // tall rows, cursor on the final cell, new codes
    loadPattern(1);
    runFrame(1'b1, 3, 2, "50Hz cursor(3,2)");
    // cursor row out of range: cursor scan dark everywhere (R4), all-ones codes
    loadPattern(2);
    runFrame(1'b1, 0, 3, "50Hz no cursor");
    // back to short rows on the following frame; frame wrap to address 0 (R2)
    loadPattern(0);
    runFrame(1'b0, 0, 0, "60Hz cursor(0,0)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule